// File: doc/BRIEF.md
# Latched Input Fault Status Register

This block keeps the one-byte input status of a power-management controller. Two comparator-driven inputs feed it. One reports input overvoltage. The other reports that the input has dropped below the turn-off level. Each event sets a sticky flag that stays set after the condition goes away. A flag is cleared in one of three ways: a clear-all strobe, an output turn-on event, or a write-one-to-clear write through the register port. A per-fault disable input stops its flag from setting at all. The alert request output is high while either flag is set.

The low-input flag is only armed once the input has risen above the turn-on threshold for the first time. Until then, brown-out readings seen during power-up neither latch the flag nor raise the alert. Only reset clears the arming state. The register sits at one command code on a simple byte write/read port. The serial framing of that port lies outside the block.

Top module: `in_stat_reg`

## Requirements
- R1: The register responds only at command code 0x7C. With `rd_en_i` high and `addr_i`=0x7C, `rdata_o` shows the status byte in the same cycle; at any other address, or with `rd_en_i` low, `rdata_o` is 0x00. After reset the status byte is 0x00.
- R2: Bit 7 is the overvoltage flag and bit 3 is the low-input flag. Bits 6:4 and 2:0 always read 0, and writes to them have no effect.
- R3: A cycle with `ovp_evt_i` high and `ovp_dis_i` low sets bit 7 from the next cycle on. The bit stays set after `ovp_evt_i` falls, until it is cleared.
- R4: A write at 0x7C clears bit 7 or bit 3 when the written data has a 1 in that position. A 0 in that position leaves the bit unchanged. Writes at other addresses change nothing.
- R5: A `clr_all_i` pulse clears both flags.
- R6: An `out_on_i` pulse clears both flags.
- R7: While `ovp_dis_i` is high, bit 7 does not set. While `uv_dis_i` is high, bit 3 does not set. A blocked event produces no alert.
- R8: Until `abv_on_i` has been high in at least one earlier cycle, `blw_off_i` sets neither bit 3 nor the alert.
- R9: Once armed, a cycle with `blw_off_i` high and `uv_dis_i` low sets bit 3 and raises `alert_o` from the next cycle on.
- R10: If a flag's set condition and any clear for it arrive in the same cycle, the flag ends up 1.
- R11: `alert_o` is high exactly while at least one flag is set. Clearing the flags does not disarm the low-input qualification; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovp_evt_i | input | 1 | Input overvoltage fault from comparator |
| abv_on_i | input | 1 | Input is above the turn-on threshold |
| blw_off_i | input | 1 | Input is below the turn-off threshold |
| ovp_dis_i | input | 1 | Disable for the overvoltage fault |
| uv_dis_i | input | 1 | Disable for the low-input fault |
| clr_all_i | input | 1 | Clear-all-faults strobe |
| out_on_i | input | 1 | Output turn-on event |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | 8 | Command code |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte |
| alert_o | output | 1 | Alert request |

## Verification
The bench holds `blw_off_i` high before arming, where a design without qualification would latch 0x08 and raise the alert at power-up. It writes zeros, writes to reserved positions, writes to a neighbouring address and writes the other flag's bit. A design with a wrong write mask would then lose the wrong flag or keep a reserved 1. It drives a set and a clear in the same cycle, where a clear-priority design would return 0x00 instead of keeping the flag. It also checks that the flag is re-latched after a clear-all, because a design that drops the arming state with the flags would no longer latch bit 3.

// File: rtl/in_stat_pkg.sv
package in_stat_pkg;
    localparam int          ADDR_W    = 8;
    localparam int          STAT_W    = 8;
    localparam int          NFLAG     = 2;
    localparam int          OV_POS    = 7;
    localparam int          UV_POS    = 3;
    localparam logic [7:0]  STAT_CMD  = 8'h7C;
    localparam int          IDX_OV    = 0;
    localparam int          IDX_UV    = 1;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    typedef struct packed {
        logic armed;
    } arm_st_t;

    function automatic int flag_pos(input int idx);
        return (idx == IDX_OV) ? OV_POS : UV_POS;
    endfunction
endpackage

// File: rtl/isr_flag_cell.sv
module isr_flag_cell
    import in_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/isr_arm.sv
module isr_arm
    import in_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    output logic armed_o
);
    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (above_i) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
endmodule

// File: rtl/isr_bus_dec.sv
module isr_bus_dec
    import in_stat_pkg::*;
#(
    parameter int              AW   = ADDR_W,
    parameter int              DW   = STAT_W,
    parameter int              NF   = NFLAG,
    parameter logic [AW-1:0]   CODE = STAT_CMD
) (
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [NF-1:0] flags_i,
    output logic [NF-1:0] w1c_o,
    output logic [DW-1:0] rdata_o
);
    logic hit;
    assign hit = (addr_i == CODE);

    for (genvar i = 0; i < NF; i++) begin : g_w1c
        localparam int P = flag_pos(i);
        assign w1c_o[i] = wr_en_i && hit && wdata_i[P];
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i && hit) begin
            for (int i = 0; i < NF; i++) rdata_o[flag_pos(i)] = flags_i[i];
        end
    end
endmodule

// File: rtl/in_stat_reg.sv
module in_stat_reg
    import in_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_CODE = STAT_CMD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovp_evt_i,
    input  logic              abv_on_i,
    input  logic              blw_off_i,
    input  logic              ovp_dis_i,
    input  logic              uv_dis_i,
    input  logic              clr_all_i,
    input  logic              out_on_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic              alert_o
);
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] w1c;
    logic             armed;

    isr_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .above_i (abv_on_i),
        .armed_o (armed)
    );

    isr_bus_dec #(
        .AW   (ADDR_W),
        .DW   (STAT_W),
        .NF   (NFLAG),
        .CODE (CMD_CODE)
    ) u_dec (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .flags_i (flag_q),
        .w1c_o   (w1c),
        .rdata_o (rdata_o)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[IDX_OV] = ovp_evt_i && !ovp_dis_i;
        set_vec[IDX_UV] = armed && blw_off_i && !uv_dis_i;
    end

    assign clr_vec = w1c | {NFLAG{clr_all_i | out_on_i}};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        isr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_q[i])
        );
    end

    assign alert_o = |flag_q;
endmodule

// File: rtl/isr_chk.sv
module isr_chk
    import in_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ovp_evt_i,
    input logic              abv_on_i,
    input logic              blw_off_i,
    input logic              ovp_dis_i,
    input logic              uv_dis_i,
    input logic              clr_all_i,
    input logic              out_on_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [STAT_W-1:0] wdata_i,
    input logic [STAT_W-1:0] rdata_o,
    input logic              alert_o,
    input logic [NFLAG-1:0]  flag_q
);
    logic seen_q;
    logic ov_clr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (abv_on_i) seen_q <= 1'b1;
    end
    assign ov_clr = clr_all_i || out_on_i ||
                    (wr_en_i && addr_i == STAT_CMD && wdata_i[OV_POS]);

    AST_OV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_evt_i && !ovp_dis_i) |=> flag_q[IDX_OV]);                 // R3
    AST_OV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[IDX_OV] && !ov_clr) |=> flag_q[IDX_OV]);                // R3
    AST_OV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[IDX_OV] && ovp_dis_i) |=> !flag_q[IDX_OV]);            // R7
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_i && !ovp_evt_i) |=> !flag_q[IDX_OV]);                 // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[6:4] == 3'b000) && (rdata_o[2:0] == 3'b000));          // R2
    AST_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !flag_q[IDX_UV]);                                   // R8
    AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_o) |-> $past(ovp_evt_i || blw_off_i));              // R11
endmodule

bind in_stat_reg isr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovp_evt_i (ovp_evt_i),
    .abv_on_i  (abv_on_i),
    .blw_off_i (blw_off_i),
    .ovp_dis_i (ovp_dis_i),
    .uv_dis_i  (uv_dis_i),
    .clr_all_i (clr_all_i),
    .out_on_i  (out_on_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .alert_o   (alert_o),
    .flag_q    (flag_q)
);

// File: tb/in_stat_reg_test.sv
`timescale 1ns/1ps
module in_stat_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovp_evt_i = 0, abv_on_i = 0, blw_off_i = 0;
    logic       ovp_dis_i = 0, uv_dis_i = 0, clr_all_i = 0, out_on_i = 0;
    logic       wr_en_i = 0, rd_en_i = 0;
    logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       alert_o;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    in_stat_reg uut (
        .clk(clk), .rst_n(rst_n), .ovp_evt_i(ovp_evt_i), .abv_on_i(abv_on_i),
        .blw_off_i(blw_off_i), .ovp_dis_i(ovp_dis_i), .uv_dis_i(uv_dis_i),
        .clr_all_i(clr_all_i), .out_on_i(out_on_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .alert_o(alert_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr_i = a; rd_en_i = 1'b1; #1;
        d = rdata_o;
        rd_en_i = 1'b0; addr_i = 8'h00;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        cyc();
        wr_en_i = 1'b0; addr_i = 8'h00; wdata_i = 8'h00;
    endtask

    task automatic expect_stat(input string req, input logic [7:0] exp);
        logic [7:0] d;
        rd(8'h7C, d);
        chk(req, d, exp);
        chk({req, " alert"}, {7'd0, alert_o}, {7'd0, exp != 8'h00});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        expect_stat("R1 reset", 8'h00);
        rd(8'h7B, d);
        chk("R1 other addr", d, 8'h00);
    endtask

    task automatic t_unarmed();
        blw_off_i = 1; repeat (3) cyc(); blw_off_i = 0; cyc();
        expect_stat("R8 unarmed low input", 8'h00);
    endtask

    task automatic t_ovp_latch();
        logic [7:0] d;
        ovp_evt_i = 1; cyc(); ovp_evt_i = 0; cyc(); cyc();
        expect_stat("R3 ov latched", 8'h80);
        rd(8'h7D, d);
        chk("R1 read other addr", d, 8'h00);
    endtask

    task automatic t_w1c();
        wr(8'h7C, 8'h00); expect_stat("R4 write zero", 8'h80);
        wr(8'h7B, 8'hFF); expect_stat("R4 other addr write", 8'h80);
        wr(8'h7C, 8'h08); expect_stat("R4 other bit write", 8'h80);
        wr(8'h7C, 8'h80); expect_stat("R4 w1c bit7", 8'h00);
        wr(8'h7C, 8'hFF); expect_stat("R2 reserved write", 8'h00);
    endtask

    task automatic t_arm_clear();
        abv_on_i = 1; cyc(); abv_on_i = 0;
        blw_off_i = 1; cyc(); blw_off_i = 0; cyc();
        expect_stat("R9 low input latched", 8'h08);
        ovp_evt_i = 1; cyc(); ovp_evt_i = 0;
        expect_stat("R2 both flags", 8'h88);
        wr(8'h7C, 8'h08); expect_stat("R4 w1c bit3", 8'h80);
        clr_all_i = 1; cyc(); clr_all_i = 0;
        expect_stat("R5 clear all", 8'h00);
        blw_off_i = 1; ovp_evt_i = 1; cyc(); blw_off_i = 0; ovp_evt_i = 0;
        expect_stat("R11 arming kept", 8'h88);
        out_on_i = 1; cyc(); out_on_i = 0;
        expect_stat("R6 output on clears", 8'h00);
    endtask

    task automatic t_disable();
        ovp_dis_i = 1; uv_dis_i = 1;
        ovp_evt_i = 1; blw_off_i = 1; repeat (2) cyc();
        ovp_evt_i = 0; blw_off_i = 0; cyc();
        ovp_dis_i = 0; uv_dis_i = 0; cyc();
        expect_stat("R7 disabled faults", 8'h00);
    endtask

    task automatic t_set_wins();
        ovp_evt_i = 1; clr_all_i = 1; cyc(); clr_all_i = 0; ovp_evt_i = 0;
        expect_stat("R10 set vs clear all", 8'h80);
        blw_off_i = 1; addr_i = 8'h7C; wdata_i = 8'h88; wr_en_i = 1; cyc();
        wr_en_i = 0; blw_off_i = 0; addr_i = 8'h00; wdata_i = 8'h00;
        expect_stat("R10 set vs w1c", 8'h08);
        ovp_evt_i = 1; out_on_i = 1; cyc(); ovp_evt_i = 0; out_on_i = 0;
        expect_stat("R10 set vs output on", 8'h80);
        wr(8'h7C, 8'h80);
        expect_stat("R11 alert drops", 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_unarmed();
        t_ovp_latch();
        t_w1c();
        t_arm_clear();
        t_disable();
        t_set_wins();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule